// File: doc/BRIEF.md
# Crystal Oscillator Failure Detector

This block watches a crystal clock from a backup ring-oscillator clock that never stops. The crystal is brought into the backup domain as a plain signal and synchronised. Its rising edges are then counted apart in backup-clock cycles. Software programs a limit, chosen to match the lowest crystal frequency that is still acceptable, for example 20 kHz. Once the detector is armed and one crystal period grows longer than that limit, the block raises a reset request. It also sets a sticky flag.

The reset request stays high for as long as the crystal stays slow. It drops only after a set number of back-to-back crystal periods have been measured inside the limit. All of this time the detector keeps running on the backup clock. While software has put the device into stop mode, the crystal is expected to be silent, so the check is masked. The arming bit and the flag each have their own clearing rules. The arming bit is cleared by a power-fail reset or by a software write of 0. The flag is cleared by a software clear strobe or by a power-on reset.

Top module: `osc_fail_detect`

## Requirements
- R1: While `por_n` is low at a clock edge, the block clears `det_en`, `fail_flag` and `fail_rst` to 0 at that edge.
- R2: At an edge where `en_wr` is 1, `det_en` takes the value of `en_wdata`. At an edge where `en_wr` is 0, `det_en` keeps its value.
- R3: While the block is armed and `stop_mode` is 0, these two rules hold. A steady crystal whose rising edges are at most `limit`+1 backup cycles apart never raises `fail_rst`. A crystal whose edges are `limit`+2 or more cycles apart raises it.
- R4: Suppose the crystal input is held still and `det_en` is written to 1 at edge w. Then `fail_rst` is still 0 after edge w+`limit`+1 and is 1 after edge w+`limit`+2.
- R5: Once raised, `fail_rst` stays 1 for as long as the crystal stays slow or stopped.
- R6: While `fail_rst` is 1, only some crystal edges count as good: those that come at most `limit`+1 cycles after the previous edge. Any stretch longer than `limit` cycles resets the count of good edges. `fail_rst` is released at the RECOVER_N-th consecutive good edge. The first edge after a long gap does not count.
- R7: `fail_flag` becomes 1 at the same edge at which `fail_rst` rises. It stays 1 after `fail_rst` is released.
- R8: A high `flag_clr` clears `fail_flag`, and so does a power-on reset. If a failure is detected at the same edge as `flag_clr`, `fail_flag` becomes 1.
- R9: A low `pfr_n` clears `det_en` and releases `fail_rst`. It leaves `fail_flag` unchanged.
- R10: While `stop_mode` is 1, a stopped crystal raises no `fail_rst` and sets no `fail_flag`.
- R11: While `det_en` is 0, no failure is detected. If `det_en` is written to 0 while `fail_rst` is 1, `fail_rst` is released one edge after `det_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bk_clk | input | 1 | Backup ring-oscillator clock; clocks the whole block |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| pfr_n | input | 1 | Power-fail reset, synchronous, active low |
| xtal_in | input | 1 | Crystal clock, sampled as data |
| stop_mode | input | 1 | High while software has stopped the crystal |
| en_wr | input | 1 | Write strobe for the arming bit |
| en_wdata | input | 1 | Value written to the arming bit |
| flag_clr | input | 1 | Software clear strobe for the failure flag |
| limit | input | CNT_W | Longest accepted gap between crystal edges, minus one, in backup cycles |
| det_en | output | 1 | Arming bit |
| fail_rst | output | 1 | Reset request, held while the failure lasts |
| fail_flag | output | 1 | Sticky failure flag |

## Verification
The bench builds the block with CNT_W = 5, RECOVER_N = 3 and a limit of 12. With these values it can sweep every crystal period from 3 up to 17 backup cycles. That covers both sides of the pass/fail boundary at 13 and 14 cycles. The 5-bit counter saturates at 31, so the stopped-crystal cases reach saturation within a few dozen cycles. A recovery count of three means release can be checked one edge before it is due and again exactly at the edge where it happens.

// File: rtl/ofd_pkg.sv
// Shared types for the oscillator failure detector.
package ofd_pkg;
    typedef enum logic {
        ST_WATCH  = 1'b0,
        ST_FAILED = 1'b1
    } ofd_state_t;
endpackage

// File: rtl/ofd_edge_sync.sv
// Brings the crystal clock into the backup domain as data and emits a
// one-cycle pulse for each rising edge.
// Assumes: the crystal runs well below half the backup clock rate near
// the threshold, so each level lasts at least one backup cycle.
module ofd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shr;

    // Synchroniser chain followed by one history stage for edge detection
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) shr[0] <= 1'b0;
                    else        shr[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) shr[g] <= 1'b0;
                    else        shr[g] <= shr[g-1];
                end
            end
        end
    endgenerate

    assign rise = shr[STAGES-1] & ~shr[STAGES];

    // R3: an edge pulse never lasts two cycles
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ofd_period_cnt.sv
// Counts backup-clock cycles since the last crystal rising edge and
// saturates at all ones. The count is held at zero while checking is inactive.
// Assumes: rise is a single-cycle pulse from the edge synchroniser.
module ofd_period_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             rise,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Gap counter: restart on edge, count up, saturate at the top value
    always_ff @(posedge clk) begin
        if (!rst_n || !active)   cnt <= '0;
        else if (rise)           cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // R3: the count changes only by one step up, a restart or a hold
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == CNT_MAX)));
endmodule

// File: rtl/ofd_fail_fsm.sv
// Failure state machine. It enters the failed state when the gap count
// passes the limit. It leaves again after RECOVER_N consecutive crystal
// edges that each arrive within the limit.
// Assumes: cnt comes from ofd_period_cnt, and limit stays below the top count.
module ofd_fail_fsm
    import ofd_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int RECOVER_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             active,
    input  logic             rise,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] limit,
    output logic             fail_rst,
    output logic             fail_enter
);
    localparam int GOOD_W = (RECOVER_N < 2) ? 1 : $clog2(RECOVER_N + 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(RECOVER_N - 1);

    ofd_state_t        st;
    logic [GOOD_W-1:0] good;
    logic              slow;

    assign slow = (cnt > limit);

    // State and good-edge run counter
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st   <= ST_WATCH;
            good <= '0;
        end else begin
            case (st)
                ST_WATCH: begin
                    if (active && slow) begin
                        st   <= ST_FAILED;
                        good <= '0;
                    end
                end
                default: begin
                    if (slow) begin
                        good <= '0;
                    end else if (rise) begin
                        if (good == GOOD_LAST) begin
                            st   <= ST_WATCH;
                            good <= '0;
                        end else begin
                            good <= good + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign fail_rst   = (st == ST_FAILED);
    assign fail_enter = rst_n && en && (st == ST_WATCH) && active && slow;

    // R3
    rise_needs_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_rst) |-> $past(cnt > limit));

    // R6
    release_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail_rst) |-> $past(rise || !en || !rst_n));
endmodule

// File: rtl/ofd_ctrl_regs.sv
// Arming bit and sticky failure flag, each with its own clearing rules.
// Assumes: both resets are synchronous and active low, and por_n takes priority.
module ofd_ctrl_regs (
    input  logic clk,
    input  logic por_n,
    input  logic pfr_n,
    input  logic en_wr,
    input  logic en_wdata,
    input  logic flag_clr,
    input  logic fail_enter,
    output logic det_en,
    output logic fail_flag
);
    // Arming bit: cleared by either reset, otherwise set or cleared by software
    always_ff @(posedge clk) begin
        if (!por_n || !pfr_n) det_en <= 1'b0;
        else if (en_wr)       det_en <= en_wdata;
    end

    // Sticky flag: a new failure wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!por_n)          fail_flag <= 1'b0;
        else if (fail_enter) fail_flag <= 1'b1;
        else if (flag_clr)   fail_flag <= 1'b0;
    end

    // R8
    flag_clear_src_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(fail_flag) |-> $past(flag_clr || !por_n));

    // R9 and R2
    en_clear_src_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(det_en) |-> $past((en_wr && !en_wdata) || !pfr_n || !por_n));
endmodule

// File: rtl/osc_fail_detect.sv
// Top level of the oscillator failure detector. Everything runs on the
// backup clock. The crystal is sampled as data, and the gap between its
// edges is compared with a software-set limit.
// Assumes: bk_clk keeps running while the crystal is slow or stopped.
module osc_fail_detect #(
    parameter int CNT_W       = 16,
    parameter int RECOVER_N   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             bk_clk,
    input  logic             por_n,
    input  logic             pfr_n,
    input  logic             xtal_in,
    input  logic             stop_mode,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] limit,
    output logic             det_en,
    output logic             fail_rst,
    output logic             fail_flag
);
    logic             core_rst_n;
    logic             active;
    logic             rise;
    logic             fail_enter;
    logic [CNT_W-1:0] cnt;

    assign core_rst_n = por_n & pfr_n;
    assign active     = det_en & ~stop_mode;

    ofd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (bk_clk),
        .rst_n (por_n),
        .din (xtal_in),
        .rise (rise)
    );

    ofd_period_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk (bk_clk),
        .rst_n (core_rst_n),
        .active (active),
        .rise (rise),
        .cnt (cnt)
    );

    ofd_fail_fsm #(.CNT_W(CNT_W), .RECOVER_N(RECOVER_N)) u_fsm (
        .clk (bk_clk),
        .rst_n (core_rst_n),
        .en (det_en),
        .active (active),
        .rise (rise),
        .cnt (cnt),
        .limit (limit),
        .fail_rst (fail_rst),
        .fail_enter (fail_enter)
    );

    ofd_ctrl_regs u_regs (
        .clk (bk_clk),
        .por_n (por_n),
        .pfr_n (pfr_n),
        .en_wr (en_wr),
        .en_wdata (en_wdata),
        .flag_clr (flag_clr),
        .fail_enter (fail_enter),
        .det_en (det_en),
        .fail_flag (fail_flag)
    );

    // R10
    no_fail_in_stop_chk: assert property (@(posedge bk_clk) disable iff (!por_n)
        $rose(fail_rst) |-> $past(!stop_mode && det_en));

    // R7
    flag_with_fail_chk: assert property (@(posedge bk_clk) disable iff (!por_n)
        $rose(fail_rst) |-> fail_flag);

    // R11
    disarm_release_chk: assert property (@(posedge bk_clk) disable iff (!por_n)
        !det_en |=> !fail_rst);
endmodule

// File: tb/test_osc_fail_detect.sv
module test_osc_fail_detect;
    localparam int CW   = 5;
    localparam int RN   = 3;
    localparam int LIM  = 12;

    logic          bk_clk = 1'b0;
    logic          por_n = 1'b0;
    logic          pfr_n = 1'b1;
    logic          xtal_in = 1'b0;
    logic          stop_mode = 1'b0;
    logic          en_wr = 1'b0;
    logic          en_wdata = 1'b0;
    logic          flag_clr = 1'b0;
    logic [CW-1:0] limit = CW'(LIM);
    logic          det_en, fail_rst, fail_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 bk_clk = ~bk_clk;

    osc_fail_detect #(.CNT_W(CW), .RECOVER_N(RN), .SYNC_STAGES(2)) i_osc_fail_detect (
        .bk_clk (bk_clk),
        .por_n (por_n),
        .pfr_n (pfr_n),
        .xtal_in (xtal_in),
        .stop_mode (stop_mode),
        .en_wr (en_wr),
        .en_wdata (en_wdata),
        .flag_clr (flag_clr),
        .limit (limit),
        .det_en (det_en),
        .fail_rst (fail_rst),
        .fail_flag (fail_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge bk_clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_por();
        por_n = 1'b0;
        tick(2);
        por_n = 1'b1;
        tick(1);
    endtask

    task automatic write_en(input logic v);
        en_wr = 1'b1;
        en_wdata = v;
        tick(1);
        en_wr = 1'b0;
        en_wdata = 1'b0;
    endtask

    task automatic run_xtal(input int per, input int n);
        for (int i = 0; i < n; i++) begin
            xtal_in = 1'b1;
            tick(per / 2);
            xtal_in = 1'b0;
            tick(per - per / 2);
        end
    endtask

    initial begin
        repeat (100000) @(posedge bk_clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(1);
        do_por();
        // R1 reset state
        check("R1 det_en", int'(det_en), 0);
        check("R1 fail_flag", int'(fail_flag), 0);
        check("R1 fail_rst", int'(fail_rst), 0);

        // R4 exact latency with a still crystal; R8 set wins over clear
        en_wr = 1'b1;
        en_wdata = 1'b1;
        tick(1);
        en_wr = 1'b0;
        check("R2 det_en set", int'(det_en), 1);
        tick(LIM + 1);
        check("R4 fail_rst before", int'(fail_rst), 0);
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        check("R4 fail_rst at limit+2", int'(fail_rst), 1);
        check("R8 set beats clear", int'(fail_flag), 1);

        // R5 held while stopped (counter saturates)
        tick(40);
        check("R5 held", int'(fail_rst), 1);

        // R6 release only at the RN-th good edge after the first
        run_xtal(8, RN);
        tick(2);
        check("R6 not yet released", int'(fail_rst), 1);
        run_xtal(8, 1);
        check("R6 released", int'(fail_rst), 0);
        check("R7 flag sticky", int'(fail_flag), 1);

        // R11 disarm releases failure
        tick(LIM + 4);
        check("R5 refail", int'(fail_rst), 1);
        write_en(1'b0);
        tick(1);
        check("R11 released", int'(fail_rst), 0);
        check("R2 det_en cleared", int'(det_en), 0);
        en_wr = 1'b0;
        en_wdata = 1'b1;
        tick(2);
        check("R2 no write keeps", int'(det_en), 0);
        en_wdata = 1'b0;
        tick(3 * LIM);
        check("R11 no detect disarmed", int'(fail_rst), 0);

        // R9 power-fail reset
        write_en(1'b1);
        tick(LIM + 4);
        check("R9 precondition", int'(fail_rst), 1);
        pfr_n = 1'b0;
        tick(1);
        pfr_n = 1'b1;
        check("R9 det_en", int'(det_en), 0);
        check("R9 fail_rst", int'(fail_rst), 0);
        check("R9 flag kept", int'(fail_flag), 1);
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
        check("R8 software clear", int'(fail_flag), 0);

        // R8 power-on reset clears flag
        write_en(1'b1);
        tick(LIM + 4);
        check("R8 precondition", int'(fail_flag), 1);
        do_por();
        check("R8 por clears flag", int'(fail_flag), 0);
        check("R1 por det_en", int'(det_en), 0);

        // R10 stop mode masks
        stop_mode = 1'b1;
        write_en(1'b1);
        tick(3 * LIM);
        check("R10 no fail_rst", int'(fail_rst), 0);
        check("R10 no flag", int'(fail_flag), 0);
        stop_mode = 1'b0;
        run_xtal(4, 10);
        check("R10 resume fast", int'(fail_rst), 0);

        // R3 period sweep across the boundary limit+1 / limit+2
        for (int p = 3; p <= LIM + 5; p++) begin
            do_por();
            write_en(1'b1);
            run_xtal(p, 6);
            check($sformatf("R3 period %0d", p), int'(fail_rst), (p > LIM + 1) ? 1 : 0);
            check($sformatf("R7 period %0d", p), int'(fail_flag), (p > LIM + 1) ? 1 : 0);
            if (p > LIM + 1) begin
                run_xtal(4, 20);
                check($sformatf("R6 recover %0d", p), int'(fail_rst), 0);
                check($sformatf("R7 sticky %0d", p), int'(fail_flag), 1);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule